// File: doc/BRIEF.md
# Asynchronous Memory Bus to Host-Port Bridge

This block sits between a host processor's asynchronous external-memory bus and the host port of a slave processor, both timed from one clock. The host opens a strobe phase of programmed length and samples a wait input. It only extends the phase if wait is already high by the second rising edge before the phase would end. The slave port reports completion on a ready line. For reads that line comes soon after the slave strobe starts. For writes it only comes after the slave strobe has been removed.

To close this loop, the bridge raises host wait in the same cycle it sees a new access and starts the slave strobe on the next cycle. For a write it removes the slave strobe after a short fixed pulse, so the slave's late write ready can still stretch the host strobe. A timeout counter releases the host if ready never comes and sets a sticky flag. A write that timed out blocks any new slave strobe until the slave finally reports ready. As a build-time option, writes can run open loop: the bridge ignores ready and holds wait for a fixed count.

Top module: `hostport_bridge`

## Requirements
- R1: After reset, host wait, slave strobe and the timeout flag are low. When the host presents an access (select and strobe high) while the bridge is idle, host wait goes high in that same cycle, and the slave strobe rises on the next cycle.
- R2: On a read, the slave strobe stays high until the cycle after the host strobe drops. Host wait falls one cycle after the bridge samples slave ready. If ready is sampled D cycles after the slave strobe rises, wait is high for 1+D cycles.
- R3: On a write, the slave strobe is high for exactly STB_CYC cycles and falls while host wait is still high.
- R4: On a closed-loop write, host wait is released one cycle after slave ready is sampled. If ready is sampled D cycles after the slave strobe falls, wait is high for STB_CYC+1+D cycles.
- R5: If ready does not come within TMO_CYC waiting cycles, the bridge releases host wait anyway and sets the timeout flag. A read then waits TMO_CYC cycles and a write waits STB_CYC+TMO_CYC cycles. Ready that arrives in the last waiting cycle counts as success and leaves the flag low.
- R6: After a write has timed out, no new slave strobe starts until slave ready is sampled. A host access that arrives in the meantime is held with wait high. Its slave strobe rises two cycles after the cycle in which ready is seen.
- R7: The timeout flag stays set until the clear input is pulsed high. After the pulse it reads low.
- R8: With OPEN_LOOP set, slave ready has no effect on a write: host wait stays high for exactly STB_CYC+OL_CYC cycles, even while ready is held high.
- R9: Each host strobe phase produces exactly one slave strobe, however long the host keeps its strobe high. A new slave cycle needs the host strobe to have been low first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by host bus and bridge |
| rst_n | input | 1 | Active-low synchronous reset |
| hst_sel | input | 1 | Host chip select for the slave window |
| hst_strobe | input | 1 | Host strobe phase, high while active |
| hst_write | input | 1 | High for a write access, low for a read |
| hst_wait | output | 1 | Wait request to the host, high to stretch the strobe |
| slv_strobe | output | 1 | Regenerated data strobe to the slave port, active high |
| slv_write | output | 1 | Direction to the slave, stable through each slave cycle |
| slv_rdy | input | 1 | Completion indication from the slave port |
| tmo_clear | input | 1 | Clears the sticky timeout flag |
| tmo_flag | output | 1 | Sticky flag: a cycle ended by timeout |

## Verification
The main instance is built with a two-cycle write strobe and an eight-cycle timeout. This puts the ready-in-last-cycle boundary and both timeout paths only a few cycles from the start of an access, and a ready delay of twelve cycles puts the write drain well beyond the host's own release. A second instance has open-loop writes with a five-cycle fixed wait and its ready tied high, so ignoring ready shows up directly in the wait length. Each expected wait length and strobe length follows from the formulas in the requirements and the ready delay the bench's slave model is given.

// File: rtl/hostport_bridge.sv
module hostport_bridge #(
  parameter int STB_CYC   = 3,
  parameter int TMO_CYC   = 16,
  parameter int OL_CYC    = 6,
  parameter bit OPEN_LOOP = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hst_sel,
  input  logic hst_strobe,
  input  logic hst_write,
  output logic hst_wait,
  output logic slv_strobe,
  output logic slv_write,
  input  logic slv_rdy,
  input  logic tmo_clear,
  output logic tmo_flag
);

  localparam int MAXC = (STB_CYC > TMO_CYC) ? ((STB_CYC > OL_CYC) ? STB_CYC : OL_CYC)
                                            : ((TMO_CYC > OL_CYC) ? TMO_CYC : OL_CYC);
  localparam int CW = $clog2(MAXC + 1);
  localparam logic [CW-1:0] STB_LAST = CW'(STB_CYC - 1);
  localparam logic [CW-1:0] TMO_LAST = CW'(TMO_CYC - 1);
  localparam logic [CW-1:0] OL_LAST  = CW'(OL_CYC - 1);

  typedef enum logic [2:0] {IDLE, R_STB, R_HOLD, W_STB, W_WAIT, W_DRAIN} st_t;

  st_t st;
  logic [CW-1:0] cnt;
  logic armed, wr_q, tmo_set;

  wire pend  = hst_sel && hst_strobe && armed;
  wire start = (st == IDLE) && pend;

  assign hst_wait   = pend || (st == R_STB) || (st == W_STB) || (st == W_WAIT);
  assign slv_strobe = (st == R_STB) || (st == R_HOLD) || (st == W_STB);
  assign slv_write  = wr_q;

  always_comb begin
    tmo_set = 1'b0;
    if (st == R_STB && !slv_rdy && cnt == TMO_LAST) tmo_set = 1'b1;
    if (!OPEN_LOOP && st == W_WAIT && !slv_rdy && cnt == TMO_LAST) tmo_set = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= IDLE;
      cnt   <= '0;
      armed <= 1'b1;
      wr_q  <= 1'b0;
    end else begin
      if (start) armed <= 1'b0;
      else if (!hst_strobe) armed <= 1'b1;
      case (st)
        IDLE:
          if (start) begin
            st   <= hst_write ? W_STB : R_STB;
            wr_q <= hst_write;
            cnt  <= '0;
          end
        R_STB:
          if (slv_rdy || cnt == TMO_LAST) st <= R_HOLD;
          else cnt <= cnt + 1'b1;
        R_HOLD:
          if (!hst_strobe || !hst_sel) st <= IDLE;
        W_STB:
          if (cnt == STB_LAST) begin
            st  <= W_WAIT;
            cnt <= '0;
          end else cnt <= cnt + 1'b1;
        W_WAIT:
          if (OPEN_LOOP) begin
            if (cnt == OL_LAST) st <= IDLE;
            else cnt <= cnt + 1'b1;
          end else if (slv_rdy) st <= IDLE;
          else if (cnt == TMO_LAST) st <= W_DRAIN;
          else cnt <= cnt + 1'b1;
        W_DRAIN:
          if (slv_rdy) st <= IDLE;
        default: st <= IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) tmo_flag <= 1'b0;
    else if (tmo_set) tmo_flag <= 1'b1;
    else if (tmo_clear) tmo_flag <= 1'b0;
  end

  assert_wait_before_strobe_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(slv_strobe) |-> $past(hst_wait));

  assert_read_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (slv_strobe && !slv_write && slv_rdy && hst_wait) |=> !hst_wait);

  assert_write_strobe_early_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(slv_strobe) && slv_write) |-> hst_wait);

  assert_no_strobe_in_drain_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == W_DRAIN && !slv_rdy) |=> !slv_strobe);

  assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_flag && !tmo_clear) |=> tmo_flag);

  assert_one_strobe_per_phase_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && hst_strobe) |=> !$rose(slv_strobe));

endmodule

// File: tb/sim_hostport_bridge.sv
`timescale 1ns/1ps
module sim_hostport_bridge;
  localparam int STB = 2, TMO = 8, OL = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic h_sel = 0, h_stb = 0, h_wr = 0, s_rdy = 0, clr = 0;
  logic h_wait, s_stb, s_wr, flag;
  logic b_sel = 0, b_stb = 0, b_wr = 0, b_rdy = 1'b1;
  logic b_wait, b_sstb, b_swr, b_flag;

  hostport_bridge #(.STB_CYC(STB), .TMO_CYC(TMO), .OL_CYC(OL), .OPEN_LOOP(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .hst_sel(h_sel), .hst_strobe(h_stb), .hst_write(h_wr),
    .hst_wait(h_wait), .slv_strobe(s_stb), .slv_write(s_wr), .slv_rdy(s_rdy),
    .tmo_clear(clr), .tmo_flag(flag));

  hostport_bridge #(.STB_CYC(STB), .TMO_CYC(TMO), .OL_CYC(OL), .OPEN_LOOP(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .hst_sel(b_sel), .hst_strobe(b_stb), .hst_write(b_wr),
    .hst_wait(b_wait), .slv_strobe(b_sstb), .slv_write(b_swr), .slv_rdy(b_rdy),
    .tmo_clear(1'b0), .tmo_flag(b_flag));

  int checks = 0, errors = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  typedef struct { int w; int s; int r; string tag; } exp_t;
  exp_t q[$];

  int slv_dly = 0;
  initial begin
    bit prev = 0, arm = 0;
    int c = 0;
    forever begin
      @(posedge clk); #1;
      s_rdy = 1'b0;
      if (s_stb && !prev && !s_wr && slv_dly >= 0) begin arm = 1; c = slv_dly; end
      if (!s_stb && prev && s_wr && slv_dly >= 0) begin arm = 1; c = slv_dly; end
      prev = s_stb;
      if (arm) begin
        if (c == 0) begin s_rdy = 1'b1; arm = 0; end
        else c--;
      end
    end
  end

  int gap = 0;
  initial begin
    bit inw = 0, pstb = 0;
    int idx = 0, last_rdy = -100, wn = 0, sn = 0, rn = 0;
    exp_t e;
    forever begin
      @(posedge clk); #2;
      idx++;
      if (s_rdy) last_rdy = idx;
      if (h_stb) inw = 1;
      if (inw) begin
        if (h_wait) wn++;
        if (s_stb) sn++;
        if (s_stb && !pstb) begin rn++; gap = idx - last_rdy; end
      end
      pstb = s_stb;
      if (inw && !h_stb && !s_stb) begin
        if (q.size() == 0) chk(0, "scoreboard empty", 0, 1);
        else begin
          e = q.pop_front();
          if (e.w >= 0) chk(wn == e.w, {e.tag, " wait cycles"}, wn, e.w);
          if (e.s >= 0) chk(sn == e.s, {e.tag, " strobe cycles"}, sn, e.s);
          chk(rn == e.r, {e.tag, " strobe starts"}, rn, e.r);
        end
        inw = 0; wn = 0; sn = 0; rn = 0;
      end
    end
  end

  task automatic host_op(input bit wr, input int d, input int ew, input int es,
                         input int hold, input string tag);
    exp_t e;
    e.w = ew; e.s = es; e.r = 1; e.tag = tag;
    q.push_back(e);
    slv_dly = d;
    @(negedge clk);
    h_sel = 1; h_stb = 1; h_wr = wr;
    forever begin
      @(posedge clk); #3;
      if (!h_wait) break;
    end
    repeat (hold) @(negedge clk);
    @(negedge clk);
    h_sel = 0; h_stb = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic clear_flag();
    @(negedge clk); clr = 1;
    @(negedge clk); clr = 0;
    @(posedge clk); #3;
    chk(flag == 1'b0, "R7 flag after clear", flag, 0);
  endtask

  task automatic ol_op(input bit wr, input int ew, input string tag);
    int n = 0;
    @(negedge clk);
    b_sel = 1; b_stb = 1; b_wr = wr;
    forever begin
      @(posedge clk); #3;
      if (!b_wait) break;
      n++;
    end
    chk(n == ew, tag, n, ew);
    @(negedge clk);
    b_sel = 0; b_stb = 0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(posedge clk); #3;
    chk(h_wait == 0, "R1 reset wait", h_wait, 0);
    chk(s_stb == 0, "R1 reset strobe", s_stb, 0);
    chk(flag == 0, "R1 reset flag", flag, 0);

    host_op(0, 0, 1, 2, 0, "R2 read d0");
    host_op(0, 3, 4, 5, 0, "R2 read d3");
    host_op(1, 0, STB + 1, STB, 0, "R3 R4 write d0");
    host_op(1, 4, STB + 5, STB, 0, "R4 write d4");
    host_op(1, TMO - 1, STB + TMO, STB, 0, "R5 write last-cycle ready");
    chk(flag == 0, "R5 no flag on last-cycle ready", flag, 0);
    host_op(0, TMO - 1, TMO, TMO + 1, 0, "R5 read last-cycle ready");
    chk(flag == 0, "R5 no flag on read last-cycle ready", flag, 0);
    host_op(1, TMO, STB + TMO, STB, 0, "R5 write timeout");
    chk(flag == 1, "R5 flag after write timeout", flag, 1);
    @(negedge clk);
    chk(flag == 1, "R7 flag holds", flag, 1);
    clear_flag();
    host_op(0, -1, TMO, TMO + 1, 0, "R5 read timeout");
    chk(flag == 1, "R5 flag after read timeout", flag, 1);
    clear_flag();

    host_op(1, TMO + 4, STB + TMO, STB, 0, "R6 write into drain");
    host_op(0, 1, -1, 3, 0, "R6 read held behind drain");
    chk(gap == 2, "R6 strobe start after ready", gap, 2);
    clear_flag();

    host_op(1, 2, STB + 3, STB, 6, "R9 long host strobe write");
    host_op(0, 1, 2, -1, 6, "R9 long host strobe read");

    ol_op(1, STB + OL, "R8 open-loop write ignores ready");
    ol_op(0, 1, "R8 open-loop read uses ready");

    repeat (4) @(negedge clk);
    chk(q.size() == 0, "scoreboard drained", q.size(), 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule